// File: doc/BRIEF.md
# Pipelined SPI ADC Read Controller

This block is an SPI master for a multi-channel successive-approximation ADC whose configuration takes effect two conversions late. Every 16-clock frame sends the 14-bit configuration word, left-aligned with two zero bits below it, and returns a left-aligned sample. The block keeps a shadow copy of the ADC configuration. After reset it writes the full start-up word and then runs two flush frames. Only after that does it accept host requests.

A host pulses `req_i` with a channel number. The block changes only the channel field of the shadow word and sends one configuration frame. It adds a second configuration frame when the channel differs from the one last delivered. It then runs a data frame, which re-sends the unchanged shadow word. The last frame's sample is right-aligned for the configured resolution and presented with a one-cycle `valid_o` strobe. Between frames, chip select stays high for at least the minimum idle time, counted in system clocks.

Top module: `adc_spi_ctrl`

## Requirements
- R1: After reset the block sends three frames before `busy_o` falls, with no `valid_o` pulse. Each frame carries the start-up word. Its fields are: bit 13 overwrite=1, bits 12:10 input mode=7, bits 9:7 channel=0, bit 6 full bandwidth=1, bits 5:3 reference select=`REF_SEL`, bits 2:1 sequencer=0 and bit 0 readback-disable=1. With `REF_SEL`=1 this is 14'h3C49, sent as frame 16'hF124.
- R2: In each frame `cs_no` is low for exactly 16 rising edges of `sclk_o`. `sclk_o` is low whenever `cs_no` is high. MOSI carries the configuration word shifted left by 2, MSB first, changing while `sclk_o` is low.
- R3: Between the end of one frame and the start of the next, `cs_no` stays high for at least `GAP_NS` ns, which is 2000 ns at the defaults.
- R4: A read of the channel last delivered takes exactly two frames: one configuration frame and one data frame.
- R5: A read of a different channel takes exactly three frames, and every one of them carries the new channel index.
- R6: A read changes only bits 9:7 of the shadow word. All other fields keep their start-up values.
- R7: `data_o` is the 16-bit word received in the last frame of the read, shifted right by 16-`RES_BITS`. With the default `RES_BITS`=14, the two low bits are dropped.
- R8: `valid_o` is high for exactly one cycle per read. `busy_o` is low in that cycle, and `busy_o` is high from the cycle after the request until then.
- R9: A request that arrives while `busy_o` is high is ignored. It adds no frame and does not change the channel being read.
- R10: The current channel changes only when a sample is delivered. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, sampled while idle |
| chan_i | input | 3 | Channel to read |
| busy_o | output | 1 | Start-up or read in progress |
| valid_o | output | 1 | One-cycle sample strobe |
| data_o | output | 16 | Right-aligned sample |
| sclk_o | output | 1 | SPI clock, idle low |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the ADC |
| miso_i | input | 1 | Serial data from the ADC |

## Verification
At the defaults a frame holds chip select low for 64 system cycles. `valid_o` rises one cycle after chip select rises at the end of the last frame. A read therefore finishes two or three frames plus gaps after the request, which is roughly 330 or 500 cycles.

The bench does not count to a fixed cycle. It samples at falling clock edges and waits for `valid_o`. It then checks the frame count and the per-frame words logged by its own ADC model, checks the data against that model's response for the final frame, and confirms one falling edge later that the strobe has dropped. The idle gap is measured in nanoseconds between chip-select edges. The clock-edge count is taken per frame.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned CFG_BITS   = 14;

  typedef struct packed {
    logic       ovr;
    logic [2:0] in_mode;
    logic [2:0] chan;
    logic       full_bw;
    logic [2:0] ref_sel;
    logic [1:0] seq;
    logic       rb_n;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_BOOT, ST_FLUSH0, ST_FLUSH1, ST_IDLE, ST_CFG_A, ST_CFG_B, ST_DATA
  } step_e;

  function automatic cfg_t boot_cfg(input logic [2:0] ref_sel);
    cfg_t c;
    c.ovr     = 1'b1;
    c.in_mode = 3'd7;
    c.chan    = 3'd0;
    c.full_bw = 1'b1;
    c.ref_sel = ref_sel;
    c.seq     = 2'd0;
    c.rb_n    = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
  import adc_spi_pkg::*;
#(
  parameter int unsigned SCLK_HALF = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] tx_i,
  output logic                  idle_o,
  output logic                  done_o,
  output logic [FRAME_BITS-1:0] rx_o,
  output logic                  sclk_o,
  output logic                  cs_no,
  output logic                  mosi_o,
  input  logic                  miso_i
);
  localparam int unsigned HW = $clog2(SCLK_HALF + 1);
  localparam int unsigned BW = $clog2(FRAME_BITS);

  logic                  busy_q, phase_q, done_q;
  logic [HW-1:0]         cnt_q;
  logic [BW-1:0]         bit_q;
  logic [FRAME_BITS-1:0] tx_q, rx_q;
  logic                  half_end;

  assign half_end = (cnt_q == HW'(SCLK_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          phase_q <= 1'b0;
          cnt_q   <= '0;
          bit_q   <= '0;
          tx_q    <= tx_i;
        end
      end else if (!half_end) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        if (!phase_q) begin
          phase_q <= 1'b1;
          rx_q    <= {rx_q[FRAME_BITS-2:0], miso_i};
        end else begin
          phase_q <= 1'b0;
          if (bit_q == BW'(FRAME_BITS - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign idle_o = !busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = phase_q;
  assign cs_no  = !busy_q;
  assign mosi_o = tx_q[FRAME_BITS-1];
endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned GAP_NS = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ready_o
);
  localparam longint unsigned GAP_CYC =
    (longint'(CLK_HZ) * longint'(GAP_NS) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int unsigned GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= GW'(GAP_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
  import adc_spi_pkg::*;
#(
  parameter int unsigned RES_BITS = 14,
  parameter logic [2:0]  REF_SEL  = 3'd1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [2:0]            chan_i,
  input  logic                  eng_idle_i,
  input  logic                  gap_ok_i,
  input  logic                  done_i,
  input  logic [FRAME_BITS-1:0] rx_i,
  output logic                  start_o,
  output logic [FRAME_BITS-1:0] tx_o,
  output logic                  busy_o,
  output logic                  valid_o,
  output logic [FRAME_BITS-1:0] data_o
);
  localparam int unsigned SHIFT = FRAME_BITS - RES_BITS;

  step_e                 st_q;
  cfg_t                  shadow_q;
  logic [2:0]            cur_q, tgt_q;
  logic                  inflight_q, valid_q;
  logic [FRAME_BITS-1:0] data_q;

  assign start_o = (st_q != ST_IDLE) && !inflight_q && eng_idle_i && gap_ok_i;
  assign tx_o    = {shadow_q, {(FRAME_BITS - CFG_BITS){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_BOOT;
      shadow_q   <= boot_cfg(REF_SEL);
      cur_q      <= 3'd0;
      tgt_q      <= 3'd0;
      inflight_q <= 1'b0;
      valid_q    <= 1'b0;
      data_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      if (start_o) inflight_q <= 1'b1;
      if (st_q == ST_IDLE) begin
        if (req_i) begin
          tgt_q         <= chan_i;
          shadow_q.chan <= chan_i;
          st_q          <= ST_CFG_A;
        end
      end else if (done_i) begin
        inflight_q <= 1'b0;
        unique case (st_q)
          ST_BOOT:   st_q <= ST_FLUSH0;
          ST_FLUSH0: st_q <= ST_FLUSH1;
          ST_FLUSH1: st_q <= ST_IDLE;
          ST_CFG_A:  st_q <= (tgt_q == cur_q) ? ST_DATA : ST_CFG_B;
          ST_CFG_B:  st_q <= ST_DATA;
          ST_DATA: begin
            data_q  <= rx_i >> SHIFT;
            valid_q <= 1'b1;
            cur_q   <= tgt_q;
            st_q    <= ST_IDLE;
          end
          default:   st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/adc_spi_ctrl.sv
module adc_spi_ctrl
  import adc_spi_pkg::*;
#(
  parameter int unsigned RES_BITS  = 14,
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned GAP_NS    = 2000,
  parameter int unsigned SCLK_HALF = 2,
  parameter logic [2:0]  REF_SEL   = 3'd1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [2:0]  chan_i,
  output logic        busy_o,
  output logic        valid_o,
  output logic [15:0] data_o,
  output logic        sclk_o,
  output logic        cs_no,
  output logic        mosi_o,
  input  logic        miso_i
);
  logic                  start, eng_idle, done, gap_ok;
  logic [FRAME_BITS-1:0] tx_word, rx_word;

  adc_read_seq #(.RES_BITS(RES_BITS), .REF_SEL(REF_SEL)) u_seq (
    .clk_i, .rst_ni, .req_i, .chan_i,
    .eng_idle_i(eng_idle), .gap_ok_i(gap_ok), .done_i(done), .rx_i(rx_word),
    .start_o(start), .tx_o(tx_word), .busy_o, .valid_o, .data_o
  );

  adc_spi_frame #(.SCLK_HALF(SCLK_HALF)) u_frame (
    .clk_i, .rst_ni, .start_i(start), .tx_i(tx_word),
    .idle_o(eng_idle), .done_o(done), .rx_o(rx_word),
    .sclk_o, .cs_no, .mosi_o, .miso_i
  );

  adc_gap_timer #(.CLK_HZ(CLK_HZ), .GAP_NS(GAP_NS)) u_gap (
    .clk_i, .rst_ni, .load_i(done), .ready_o(gap_ok)
  );
endmodule

// File: rtl/adc_spi_ctrl_chk.sv
module adc_spi_ctrl_chk #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned GAP_NS = 2000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic busy_o,
  input logic valid_o,
  input logic sclk_o,
  input logic cs_no
);
  localparam longint unsigned GAP_CYC =
    (longint'(CLK_HZ) * longint'(GAP_NS) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int unsigned GW = $clog2(GAP_CYC + 1);

  logic          sclk_q, seen_q;
  logic [5:0]    rises_q;
  logic [GW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      seen_q  <= 1'b0;
      rises_q <= '0;
      hi_q    <= '0;
    end else begin
      sclk_q <= sclk_o;
      if (cs_no) rises_q <= '0;
      else if (sclk_o && !sclk_q) rises_q <= rises_q + 1'b1;
      if (!cs_no) begin
        hi_q   <= '0;
        seen_q <= 1'b1;
      end else if (hi_q != GW'(GAP_CYC)) begin
        hi_q <= hi_q + 1'b1;
      end
    end
  end

  p_sclk_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_frame_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> rises_q == 6'd16);
  p_gap_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && seen_q) |-> hi_q == GW'(GAP_CYC));
  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_valid_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);
  p_req_starts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
endmodule

bind adc_spi_ctrl adc_spi_ctrl_chk #(.CLK_HZ(CLK_HZ), .GAP_NS(GAP_NS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o),
  .valid_o(valid_o), .sclk_o(sclk_o), .cs_no(cs_no)
);

// File: tb/adc_spi_ctrl_test.sv
`timescale 1ns/1ps
module adc_spi_ctrl_test;
  logic        clk = 1'b0, rst_ni = 1'b0, req = 1'b0, miso = 1'b0;
  logic [2:0]  chan = 3'd0;
  logic        busy, valid, sclk, cs_n, mosi;
  logic [15:0] data;

  adc_spi_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .chan_i(chan),
    .busy_o(busy), .valid_o(valid), .data_o(data),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, nfr = 0, valid_seen = 0;
  logic [15:0] fr_word [256];
  logic [15:0] rx_sh, miso_sh;
  int   edges = 0;
  bit   in_frame = 0, finished = 0;
  realtime t_rise = 0.0;
  logic [2:0] cur_ch = 3'd0;

  function automatic logic [15:0] resp(input int n);
    return 16'((n + 3) * 16'h9E37) ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] exp_frame(input logic [2:0] ch);
    logic [13:0] c;
    c = {1'b1, 3'd7, ch, 1'b1, 3'd1, 2'd0, 1'b1};
    return {c, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // ADC model: samples MOSI on rising SCLK, shifts MISO on falling SCLK
  always @(negedge cs_n) begin
    if (rst_ni) begin
      if (nfr > 0) chk(($realtime - t_rise) >= 2000.0, "R3 gap ns",
                       int'($realtime - t_rise), 2000);
      in_frame = 1; edges = 0;
      miso_sh = resp(nfr); miso = miso_sh[15];
    end
  end
  always @(posedge sclk) if (!cs_n) begin
    rx_sh = {rx_sh[14:0], mosi}; edges++;
  end
  always @(negedge sclk) if (!cs_n) begin
    miso_sh = {miso_sh[14:0], 1'b0}; miso = miso_sh[15];
  end
  always @(posedge cs_n) if (in_frame) begin
    in_frame = 0;
    chk(edges == 16, "R2 sclk edges", edges, 16);
    if (nfr < 256) fr_word[nfr] = rx_sh;
    nfr++;
    t_rise = $realtime;
  end
  always @(posedge clk) if (valid) valid_seen++;

  task automatic do_read(input logic [2:0] ch, input bit inject);
    int start, want;
    start = nfr;
    want  = (ch == cur_ch) ? 2 : 3;
    @(negedge clk); req = 1'b1; chan = ch;
    @(negedge clk); req = 1'b0;
    chk(busy == 1'b1, "R8 busy after req", busy, 1);
    if (inject) begin
      repeat (40) @(negedge clk);
      req = 1'b1; chan = ~ch;
      @(negedge clk); req = 1'b0;
    end
    while (!valid) @(negedge clk);
    chk(busy == 1'b0, "R8 busy low at valid", busy, 0);
    if (want == 2) chk(nfr - start == 2, "R4 frames same channel", nfr - start, 2);
    else           chk(nfr - start == 3, "R5 frames new channel", nfr - start, 3);
    for (int i = start; i < nfr; i++)
      chk(fr_word[i] == exp_frame(ch), "R6 R5 frame word", fr_word[i], exp_frame(ch));
    chk(data == (resp(nfr - 1) >> 2), "R7 data", data, resp(nfr - 1) >> 2);
    @(negedge clk);
    chk(valid == 1'b0, "R8 single strobe", valid, 0);
    cur_ch = ch;
  endtask

  initial begin
    int n0;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && valid == 1'b0, "R1 reset state",
        {cs_n, sclk, valid}, 3'b100);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy in start-up", busy, 1);
    while (busy) @(negedge clk);
    chk(nfr == 3, "R1 start-up frames", nfr, 3);
    for (int i = 0; i < 3; i++)
      chk(fr_word[i] == 16'hF124, "R1 start-up word", fr_word[i], 16'hF124);
    chk(valid_seen == 0, "R1 no strobe in start-up", valid_seen, 0);

    do_read(3'd0, 0);            // R10: channel 0 current after reset
    do_read(3'd5, 0);
    do_read(3'd5, 0);
    do_read(3'd3, 1);            // R9: request while busy
    n0 = nfr;
    repeat (400) @(negedge clk);
    chk(nfr == n0 && !busy, "R9 no extra frames", nfr - n0, 0);
    do_read(3'd3, 0);            // R10: current channel is 3, not the ignored one
    do_read(3'd7, 0);
    for (int k = 0; k < 18; k++) do_read(3'($urandom_range(0, 7)), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule